// File: doc/BRIEF.md
# Masked Capability Register File for a Link-Attached Component

This block is the cache/memory capability register area of one component on a coherent link. Software reaches it over a small register bus. Each access carries a byte address, a read strobe, a write strobe, a 32-bit write word and a flag that marks an 8-byte access. Read data comes back from a register one cycle after the read strobe. When reset is applied, the block loads a primary capability header and a list of capability entries. The length of that list depends on the `COMP_TYPE` parameter. It also loads the error-reporting registers and the memory-decoder registers with their reset values.

Each writable register has a fixed write mask. A write changes only the bits that the mask allows, and every other bit keeps its value. The header words and the capability entries are constant. Reserved space, capability sets with no registers, and the decoder set when this component type lacks it all read as zero and ignore writes.

The block implements only 4-byte registers. An access flagged as 8 bytes returns zero on a read and is dropped on a write. A misaligned access is treated the same way.

Top module: `cap_regfile`

## Requirements
- R1: A 4-byte read of address 0x000 returns the primary header: bits [15:0] = 1, bits [19:16] = 1, bits [23:20] = 1, and bits [31:24] = array size. The array size comes from `COMP_TYPE`: 0 (downstream port) → 2, 1 (plain device) → 2, 2 (upstream port) → 3, 3 (type-3 device) → 3, 4 (logical device) → 3, 5 (root port) → 5.
- R2: Capability entry k (k = 0 up to array size − 1) sits at 0x004 + 4k. Each entry holds an ID in bits [15:0], a version in bits [19:16] and a byte pointer in bits [31:20]. The entries are, in order: (2, 2, 0x100), (4, 2, 0x200), (5, 1, 0x300), (6, 1, 0x400), (8, 1, 0x500). Entry slots past the array size read as zero.
- R3: In the error-reporting set, the uncorrectable mask (0x104) and the uncorrectable severity (0x108) reset to 0x1CFFF and have write mask 0x1CFFF. The correctable mask (0x110) resets to 0x7F with write mask 0x7F. The uncorrectable status (0x100), the correctable status (0x10C) and the capability/control word (0x114) always read as zero.
- R4: When the array size is at least 3, the decoder capability word at 0x300 reads as follows:
  - bits [3:0] hold the encoded decoder count (0 for one decoder, n/2 for n > 1);
  - bits [7:4] hold 1;
  - bits 8 and 9 are set;
  - bit 10 is clear.
  
  The global control word at 0x304 resets to 0 with write mask 0x3. When the array size is 2, both words read as zero and ignore writes.
- R5: Decoder i uses five registers starting at 0x310 + 0x20·i, all resetting to 0. The masks are: +0x0 base-low 0xF0000000, +0x4 base-high 0xFFFFFFFF, +0x8 size-low 0xF0000000, +0xC size-high 0xFFFFFFFF, +0x10 control 0x13FF.
- R6: A 4-byte aligned write stores (wdata & mask) | (old & ~mask). Constant words (header, entries, decoder capability) never change.
- R7: An access with `size8` = 1 reads as zero and writes nothing.
- R8: A misaligned address (addr[1:0] ≠ 0) or an address with no register reads as zero and ignores writes.
- R9: `rdata` shows the value for a read strobe in the next cycle and is zero in any cycle after one with no read strobe. A write is visible to a read issued in the next cycle.
- R10: A synchronous active-high reset returns every register to its reset value and drives `rdata` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| size8 | input | 1 | Access is 8 bytes wide (not serviced) |
| addr | input | ADDR_W | Byte address within the capability area |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |

## Verification
The bench writes all-ones to every word and then reads back every word. A wrong mask, a wrong decoder stride or a missing reserved-bit hole (bits 12 and 13 of the uncorrectable registers) would show up as a word with extra or missing bits. It builds one instance for each component type. A wrong array-size table, or a decoder set that is wrongly present or missing, would show up as a wrong header, a non-zero entry slot or a control word that accepts writes. It sends 8-byte and misaligned writes to writable words and then reads them. A design that serviced those accesses would return changed data. It also reads a word in the cycle right after writing it and checks an idle cycle. A design with an extra pipeline stage, or one that keeps stale data on the bus, would fail these reads.

// File: rtl/cap_regfile_pkg.sv
package cap_regfile_pkg;

  localparam int DW = 32;

  // Number of capability entries per component type
  function automatic int arr_size(input int ct);
    case (ct)
      0, 1:    return 2;
      2, 3, 4: return 3;
      5:       return 5;
      default: return 2;
    endcase
  endfunction

  // Encoded decoder count: 1 -> 0, otherwise n/2
  function automatic logic [3:0] dec_enc(input int n);
    if (n <= 1) return 4'd0;
    return 4'(n / 2);
  endfunction

  // Capability entry k: {pointer, version, id}
  function automatic logic [31:0] entry_word(input int k);
    case (k)
      0:       return {12'h100, 4'h2, 16'h0002};
      1:       return {12'h200, 4'h2, 16'h0004};
      2:       return {12'h300, 4'h1, 16'h0005};
      3:       return {12'h400, 4'h1, 16'h0006};
      4:       return {12'h500, 4'h1, 16'h0008};
      default: return 32'h0;
    endcase
  endfunction

  // Writable register slots: 0..2 error set, 3 decoder global control,
  // 4+5*i+j decoder i register j
  function automatic logic [15:0] slot_addr(input int s);
    case (s)
      0:       return 16'h0104;
      1:       return 16'h0108;
      2:       return 16'h0110;
      3:       return 16'h0304;
      default: return 16'(16'h0310 + 32 * ((s - 4) / 5) + 4 * ((s - 4) % 5));
    endcase
  endfunction

  function automatic logic [31:0] slot_mask(input int s);
    case (s)
      0, 1: return 32'h0001_CFFF;
      2:    return 32'h0000_007F;
      3:    return 32'h0000_0003;
      default:
        case ((s - 4) % 5)
          0, 2:    return 32'hF000_0000;
          1, 3:    return 32'hFFFF_FFFF;
          default: return 32'h0000_13FF;
        endcase
    endcase
  endfunction

  function automatic logic [31:0] slot_rst(input int s);
    case (s)
      0, 1:    return 32'h0001_CFFF;
      2:       return 32'h0000_007F;
      default: return 32'h0;
    endcase
  endfunction

endpackage

// File: rtl/cap_mreg.sv
module cap_mreg #(
  parameter int          W    = 32,
  parameter logic [W-1:0] MASK = '1,
  parameter logic [W-1:0] RSTV = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst)     q <= RSTV;
    else if (we) q <= (wdata & MASK) | (q & ~MASK);
  end

endmodule

// File: rtl/cap_hdr_rom.sv
module cap_hdr_rom
  import cap_regfile_pkg::*;
#(
  parameter int COMP_TYPE = 5,
  parameter int NUM_DEC   = 1,
  parameter int WA        = 10
) (
  input  logic [WA-1:0] widx,
  output logic [DW-1:0] val
);

  localparam int          ARR     = arr_size(COMP_TYPE);
  localparam bit          HAS_HDM = (ARR >= 3);
  localparam logic [WA-1:0] HDM_CAP_W = WA'(12'h300 >> 2);
  localparam logic [DW-1:0] PRIMARY = {8'(ARR), 4'h1, 4'h1, 16'h0001};
  localparam logic [DW-1:0] HDM_CAP = {21'd0, 1'b0, 2'b11, 4'h1, dec_enc(NUM_DEC)};

  always_comb begin
    val = '0;
    if (widx == '0)
      val = PRIMARY;
    else if (widx <= WA'(ARR))
      val = entry_word(int'(widx) - 1);
    else if (HAS_HDM && widx == HDM_CAP_W)
      val = HDM_CAP;
  end

endmodule

// File: rtl/cap_regfile.sv
module cap_regfile
  import cap_regfile_pkg::*;
#(
  parameter int COMP_TYPE = 5,
  parameter int NUM_DEC   = 1,
  parameter int ADDR_W    = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic              size8,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata
);

  localparam int ARR     = arr_size(COMP_TYPE);
  localparam bit HAS_HDM = (ARR >= 3);
  localparam int NUM_W   = HAS_HDM ? 4 + 5 * NUM_DEC : 3;
  localparam int WA      = ADDR_W - 2;

  logic [WA-1:0]    widx;
  logic             acc_ok;
  logic [NUM_W-1:0] hit;
  logic [DW-1:0]    slot_q [NUM_W];
  logic [DW-1:0]    slot_val;
  logic [DW-1:0]    hdr_val;

  assign widx   = addr[ADDR_W-1:2];
  assign acc_ok = (addr[1:0] == 2'b00) && !size8;

  for (genvar s = 0; s < NUM_W; s++) begin : g_slot
    localparam logic [WA-1:0] SW = WA'(slot_addr(s) >> 2);
    assign hit[s] = (widx == SW);
    cap_mreg #(
      .W    (DW),
      .MASK (slot_mask(s)),
      .RSTV (slot_rst(s))
    ) u_reg (
      .clk   (clk),
      .rst   (rst),
      .we    (wr_en && acc_ok && hit[s]),
      .wdata (wdata),
      .q     (slot_q[s])
    );
  end

  cap_hdr_rom #(
    .COMP_TYPE (COMP_TYPE),
    .NUM_DEC   (NUM_DEC),
    .WA        (WA)
  ) u_hdr (
    .widx (widx),
    .val  (hdr_val)
  );

  always_comb begin
    slot_val = '0;
    for (int s = 0; s < NUM_W; s++)
      if (hit[s]) slot_val = slot_val | slot_q[s];
  end

  always_ff @(posedge clk) begin
    if (rst)                  rdata <= '0;
    else if (rd_en && acc_ok) rdata <= hdr_val | slot_val;
    else                      rdata <= '0;
  end

endmodule

// File: rtl/cap_regfile_chk.sv
module cap_regfile_chk
  import cap_regfile_pkg::*;
#(
  parameter int COMP_TYPE = 5,
  parameter int ADDR_W    = 12,
  parameter int NUM_W     = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              rd_en,
  input logic              wr_en,
  input logic              size8,
  input logic [ADDR_W-1:0] addr,
  input logic [DW-1:0]     rdata,
  input logic [DW-1:0]     state [NUM_W]
);

  localparam logic [7:0] ASZ = (COMP_TYPE == 5) ? 8'd5 :
                               (COMP_TYPE >= 2 && COMP_TYPE <= 4) ? 8'd3 : 8'd2;
  localparam logic [DW-1:0] HDR = {ASZ, 24'h110001};

  p_hdr_const_r1: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !size8 && addr == '0) |=> (rdata == HDR));

  p_rd8_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (rd_en && size8) |=> (rdata == '0));

  p_misalign_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr[1:0] != 2'b00) |=> (rdata == '0));

  p_idle_zero_r9: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> (rdata == '0));

  for (genvar s = 0; s < NUM_W; s++) begin : g_chk
    localparam logic [DW-1:0] M = slot_mask(s);

    p_ro_keep_r6: assert property (@(posedge clk) disable iff (rst)
      wr_en |=> ((state[s] & ~M) == ($past(state[s]) & ~M)));

    p_wr8_drop_r7: assert property (@(posedge clk) disable iff (rst)
      (wr_en && size8) |=> (state[s] == $past(state[s])));
  end

endmodule

bind cap_regfile cap_regfile_chk #(
  .COMP_TYPE (COMP_TYPE),
  .ADDR_W    (ADDR_W),
  .NUM_W     (NUM_W)
) u_chk (
  .clk   (clk),
  .rst   (rst),
  .rd_en (rd_en),
  .wr_en (wr_en),
  .size8 (size8),
  .addr  (addr),
  .rdata (rdata),
  .state (slot_q)
);

// File: tb/sim_cap_regfile.sv
`timescale 1ns/1ps
module sim_cap_regfile;

  localparam int ND = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rd_en = 1'b0, wr_en = 1'b0, size8 = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [31:0] rd_t [5];

  int checks = 0, errors = 0;
  bit armed = 0, done = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  cap_regfile #(.COMP_TYPE(5), .NUM_DEC(ND), .ADDR_W(12)) u0 (
    .clk(clk), .rst(rst), .rd_en(rd_en), .wr_en(wr_en), .size8(size8),
    .addr(addr), .wdata(wdata), .rdata(rdata));

  for (genvar t = 0; t < 5; t++) begin : g_type
    cap_regfile #(.COMP_TYPE(t), .NUM_DEC(1), .ADDR_W(12)) u_t (
      .clk(clk), .rst(rst), .rd_en(rd_en), .wr_en(wr_en), .size8(size8),
      .addr(addr), .wdata(wdata), .rdata(rd_t[t]));
  end

  // ---------------- behavioural reference model (root port, 2 decoders)
  int unsigned mem [1024];
  int unsigned exp_rd;
  string       exp_tag;

  function automatic int unsigned wmask(input int a);
    int off;
    if (a == 'h104 || a == 'h108) return 'h1CFFF;
    if (a == 'h110) return 'h7F;
    if (a == 'h304) return 'h3;
    if (a >= 'h310 && a < 'h310 + 'h20 * ND) begin
      off = (a - 'h310) % 'h20;
      if (off == 0 || off == 8) return 32'hF000_0000;
      if (off == 4 || off == 'hC) return 32'hFFFF_FFFF;
      if (off == 'h10) return 'h13FF;
    end
    return 0;
  endfunction

  function automatic string tag_of(input int a, input bit s8);
    if (s8) return "R7";
    if (a % 4 != 0) return "R8";
    if (a == 0) return "R1";
    if (a < 'h100) return "R2";
    if (a < 'h200) return "R3";
    if (a == 'h300 || a == 'h304) return "R4";
    if (a >= 'h310 && a < 'h400) return "R5";
    return "R8";
  endfunction

  task automatic model_reset();
    foreach (mem[i]) mem[i] = 0;
    mem[0]        = 32'h0511_0001;
    mem[1]        = 32'h1002_0002;
    mem[2]        = 32'h2002_0004;
    mem[3]        = 32'h3001_0005;
    mem[4]        = 32'h4001_0006;
    mem[5]        = 32'h5001_0008;
    mem['h104/4]  = 'h1CFFF;
    mem['h108/4]  = 'h1CFFF;
    mem['h110/4]  = 'h7F;
    mem['h300/4]  = 'h311;
  endtask

  always @(posedge clk) begin
    int unsigned m;
    if (rst) begin
      model_reset();
      exp_rd  = 0;
      exp_tag = "R10";
    end else begin
      if (rd_en && !size8 && addr[1:0] == 0) exp_rd = mem[addr >> 2];
      else exp_rd = 0;
      exp_tag = rd_en ? tag_of(int'(addr), size8) : "R9";
      if (wr_en && !size8 && addr[1:0] == 0) begin
        m = wmask(int'(addr));
        mem[addr >> 2] = (wdata & m) | (mem[addr >> 2] & ~m);
      end
    end
  end

  // compared on every clock, away from the active edge
  always @(negedge clk) begin
    if (armed && !done) begin
      checks++;
      if (rdata !== exp_rd) begin
        errors++;
        $display("FAIL %s model compare: actual %h expected %h", exp_tag, rdata, exp_rd);
      end
    end
  end

  // ---------------- stimulus helpers
  task automatic rd(input int a, input bit s8 = 0);
    rd_en = 1; wr_en = 0; size8 = s8; addr = 12'(a);
    @(negedge clk);
    rd_en = 0; size8 = 0;
  endtask

  task automatic wr(input int a, input int unsigned d, input bit s8 = 0);
    wr_en = 1; rd_en = 0; size8 = s8; addr = 12'(a); wdata = d;
    @(negedge clk);
    wr_en = 0; size8 = 0;
  endtask

  task automatic chk(input string tag, input int unsigned act, input int unsigned exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic rdc(input int a, input int unsigned exp, input string tag, input bit s8 = 0);
    rd(a, s8);
    chk(tag, rdata, exp);
  endtask

  function automatic int unsigned hdr_of(input int t);
    return (t <= 1) ? 32'h0211_0001 : 32'h0311_0001;
  endfunction

  task automatic sweep_rd();
    for (int a = 0; a < 'h600; a += 4) rd(a);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected under 100000", cyc);
      summary();
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    armed = 1;
    chk("R10 reset rdata", rdata, 0);
    repeat (2) @(negedge clk);
    rst = 0;

    // R1 headers for every type
    rdc(0, 32'h0511_0001, "R1 root port header");
    rd(0);
    for (int t = 0; t < 5; t++) chk($sformatf("R1 header type %0d", t), rd_t[t], hdr_of(t));

    // R2 entries
    rdc('h04, 32'h1002_0002, "R2 entry RAS");
    rdc('h08, 32'h2002_0004, "R2 entry link");
    rdc('h0C, 32'h3001_0005, "R2 entry decoder");
    rdc('h10, 32'h4001_0006, "R2 entry ext security");
    rdc('h14, 32'h5001_0008, "R2 entry snoop");
    rdc('h18, 0, "R2 past array size");
    rd('h0C);
    for (int t = 0; t < 5; t++)
      chk($sformatf("R2 third entry type %0d", t), rd_t[t], (t <= 1) ? 0 : 32'h3001_0005);
    rd('h10);
    for (int t = 0; t < 5; t++) chk($sformatf("R2 fourth entry type %0d", t), rd_t[t], 0);

    // R3/R4 reset values
    rdc('h104, 'h1CFFF, "R3 uncorr mask reset");
    rdc('h108, 'h1CFFF, "R3 severity reset");
    rdc('h110, 'h7F, "R3 corr mask reset");
    rdc('h300, 'h311, "R4 decoder capability");
    rdc('h304, 0, "R4 global control reset");
    rd('h300);
    for (int t = 0; t < 5; t++)
      chk($sformatf("R4 decoder cap type %0d", t), rd_t[t], (t <= 1) ? 0 : 'h310);
    sweep_rd();

    // all-ones to every word
    for (int a = 0; a < 'h600; a += 4) wr(a, 32'hFFFF_FFFF);
    sweep_rd();
    rdc('h104, 'h1CFFF, "R3 uncorr mask ones");
    rdc('h110, 'h7F, "R3 corr mask ones");
    rdc('h100, 0, "R3 status read-only");
    rdc('h114, 0, "R3 cap/ctrl read-only");
    rdc('h304, 3, "R4 global control ones");
    rdc('h310, 32'hF000_0000, "R5 dec0 base low");
    rdc('h334, 32'hFFFF_FFFF, "R5 dec1 base high");
    rdc('h340, 'h13FF, "R5 dec1 control");
    rdc('h350, 0, "R5 beyond last decoder");
    rdc(0, 32'h0511_0001, "R6 header unchanged");
    rdc('h300, 'h311, "R6 decoder cap unchanged");
    rd('h304);
    for (int t = 0; t < 5; t++)
      chk($sformatf("R4 global control type %0d", t), rd_t[t], (t <= 1) ? 0 : 3);

    // R6 partial masks
    wr('h110, 'hF0F);
    rdc('h110, 'h0F, "R6 corr mask partial");
    wr('h108, 'h3005);
    rdc('h108, 'h5, "R6 reserved bits 12-13");

    // R7 8-byte accesses
    wr('h31C, 32'h1234_5678, 1);
    rdc('h31C, 32'hFFFF_FFFF, "R7 8-byte write dropped");
    rdc('h104, 0, "R7 8-byte read zero", 1);

    // R8 misaligned and unmapped
    wr('h105, 0);
    rdc('h104, 'h1CFFF, "R8 misaligned write ignored");
    rdc('h105, 0, "R8 misaligned read zero");
    wr('h700, 32'hFFFF_FFFF);
    rdc('h700, 0, "R8 unmapped write ignored");

    // R9 write then read next cycle, idle cycle
    wr('h31C, 32'hA5A5_A5A5);
    rdc('h31C, 32'hA5A5_A5A5, "R9 write visible next cycle");
    @(negedge clk);
    chk("R9 idle rdata zero", rdata, 0);

    // zero pass
    for (int a = 0; a < 'h600; a += 4) wr(a, 0);
    sweep_rd();

    // R10 reset restores values
    for (int a = 0; a < 'h600; a += 4) wr(a, 32'h5A5A_5A5A);
    rst = 1;
    repeat (2) @(negedge clk);
    chk("R10 rdata in reset", rdata, 0);
    rst = 0;
    rdc('h110, 'h7F, "R10 corr mask restored");
    rdc('h31C, 0, "R10 decoder restored");
    rdc('h304, 0, "R10 global control restored");
    sweep_rd();

    @(negedge clk);
    done = 1;
    summary();
    $finish;
  end

endmodule